// File: doc/BRIEF.md
# Level-Sensitive Interrupt Combiner with APB Register Access

This block gathers a configurable number of level-sensitive interrupt lines, anywhere from 2 to 64, and merges them into one request line for a parent interrupt controller. Each line first passes through a two-stage synchronizer. It is then gated by two per-source register layers: an enable bit that must be 1, and a mask bit that must be 0. The surviving bits form a final status word. Software reads that word to find out which sources need service. The OR of the status bits, registered once, drives the combined request.

Software reaches the registers through a zero-wait-state APB slave. Every register is split into a low word and a high word. Storage exists only for the configured sources, and every other bit reads back as zero. Software can therefore find the number of sources by writing all ones to the enable words and locating the highest bit that reads back as set. Because the inputs are levels, a status bit clears by itself once its source drops. No acknowledge write is needed.

Top module: `irq_agg_apb`

## Requirements
- R1: After reset, both enable words, both mask words and both status words read 0, and irq_out is 0.
- R2: The enable register occupies offset 0x00 (low word) and offset 0x04 (high word). Source n below 32 sits at bit n of the low word, and source n of 32 or more sits at bit n-32 of the high word. Bits for sources at or above NUM_SRC have no storage and read 0, so writing all ones and reading back gives the source count. Enable bits change only on an APB write to their own word.
- R3: The mask register occupies offset 0x08 (low word) and offset 0x0C (high word), with the same bit mapping and unimplemented-bit behaviour as enable.
- R4: Final status is at offset 0x30 (low word) and offset 0x34 (high word), with the same bit mapping. A status bit is 1 exactly when its synchronized input is 1, its enable bit is 1 and its mask bit is 0. A mask bit of 1 suppresses the source.
- R5: Status is level-sensitive. A bit stays 1 while its input is held high and returns to 0 when the input falls, with no software write. Writes to the status offsets have no effect.
- R6: An input rising at a clock edge appears in a status read two clock edges later, and in irq_out three clock edges later.
- R7: irq_out is a registered OR of all final status bits.
- R8: The APB slave has no wait states: pready is always 1 and pslverr is always 0. Reads of any unmapped offset return 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock; it also clocks the synchronizers and the output register |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data; 0 outside a read access |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_src | input | NUM_SRC | Level-sensitive interrupt inputs, active high |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest point to reach is the boundary between the two words. Source 31 and source 32 sit in different registers, and the high word is only partly implemented. A single wrong index leaves every low-word test passing. The stimulus enables only source 32 through the high enable word and drives the inputs on both sides of the boundary, expecting status in bit 0 of the high word and nothing in the low word. It then writes all ones to the high word and expects exactly NUM_SRC-32 bits to read back. Randomised enable, mask and input patterns, each held long enough for the synchronizer to settle, then cover the combined gating across both words.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int WORD_W    = 32;
    localparam int OFS_EN_LO = 'h00;
    localparam int OFS_EN_HI = 'h04;
    localparam int OFS_MK_LO = 'h08;
    localparam int OFS_MK_HI = 'h0C;
    localparam int OFS_ST_LO = 'h30;
    localparam int OFS_ST_HI = 'h34;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = d;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign q = sy_q.s2;
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int ADDR_W  = 12
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [WORD_W-1:0]  pwdata,
    input  logic [NUM_SRC-1:0] status,
    output logic [WORD_W-1:0]  prdata,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] mask_o
);
    localparam int EXT_W = 2 * WORD_W;
    localparam logic [ADDR_W-1:0] A_EN_LO = ADDR_W'(OFS_EN_LO);
    localparam logic [ADDR_W-1:0] A_EN_HI = ADDR_W'(OFS_EN_HI);
    localparam logic [ADDR_W-1:0] A_MK_LO = ADDR_W'(OFS_MK_LO);
    localparam logic [ADDR_W-1:0] A_MK_HI = ADDR_W'(OFS_MK_HI);
    localparam logic [ADDR_W-1:0] A_ST_LO = ADDR_W'(OFS_ST_LO);
    localparam logic [ADDR_W-1:0] A_ST_HI = ADDR_W'(OFS_ST_HI);

    function automatic logic [WORD_W-1:0] impl_word(input int base);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W; b++) r[b] = ((base + b) < NUM_SRC);
        return r;
    endfunction

    localparam logic [WORD_W-1:0] LO_IMPL = impl_word(0);
    localparam logic [WORD_W-1:0] HI_IMPL = impl_word(WORD_W);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] mask;
    } regs_t;

    regs_t rg_d, rg_q;

    logic wr_acc, rd_acc, mapped;
    logic [EXT_W-1:0] en_x, mk_x, st_x;

    assign wr_acc = psel && penable && pwrite;
    assign rd_acc = psel && penable && !pwrite;
    assign mapped = (paddr == A_EN_LO) || (paddr == A_EN_HI) ||
                    (paddr == A_MK_LO) || (paddr == A_MK_HI) ||
                    (paddr == A_ST_LO) || (paddr == A_ST_HI);

    // next-state: each stored bit picks its word by source index
    always_comb begin
        rg_d = rg_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (wr_acc && paddr == ((i < WORD_W) ? A_EN_LO : A_EN_HI))
                rg_d.en[i] = pwdata[i % WORD_W];
            if (wr_acc && paddr == ((i < WORD_W) ? A_MK_LO : A_MK_HI))
                rg_d.mask[i] = pwdata[i % WORD_W];
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) rg_q <= '0;
        else          rg_q <= rg_d;
    end

    // zero-extended views, unimplemented bits are constant zero
    always_comb begin
        en_x = '0;
        mk_x = '0;
        st_x = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            en_x[i] = rg_q.en[i];
            mk_x[i] = rg_q.mask[i];
            st_x[i] = status[i];
        end
    end

    always_comb begin
        prdata = '0;
        if (rd_acc) begin
            case (paddr)
                A_EN_LO: prdata = en_x[WORD_W-1:0];
                A_EN_HI: prdata = en_x[EXT_W-1:WORD_W];
                A_MK_LO: prdata = mk_x[WORD_W-1:0];
                A_MK_HI: prdata = mk_x[EXT_W-1:WORD_W];
                A_ST_LO: prdata = st_x[WORD_W-1:0];
                A_ST_HI: prdata = st_x[EXT_W-1:WORD_W];
                default: prdata = '0;
            endcase
        end
    end

    assign en_o   = rg_q.en;
    assign mask_o = rg_q.mask;

    // R2
    en_wr_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_acc && paddr == A_EN_LO) |=>
            (en_x[WORD_W-1:0] == ($past(pwdata) & LO_IMPL)));

    // R3
    mk_wr_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_acc && paddr == A_MK_HI) |=>
            (mk_x[EXT_W-1:WORD_W] == ($past(pwdata) & HI_IMPL)));

    // R2
    hi_unimpl_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_acc && paddr == A_EN_HI) |-> ((prdata & ~HI_IMPL) == '0));

    // R2
    hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
        !wr_acc |=> $stable(rg_q));

    // R8
    unmapped_rd_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_acc && !mapped) |-> (prdata == '0));
endmodule

// File: rtl/irq_agg_gate.sv
module irq_agg_gate #(
    parameter int NUM_SRC = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] sync_in,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] status,
    output logic               irq_out
);
    typedef struct packed {
        logic irq;
    } gate_t;

    gate_t gt_d, gt_q;

    always_comb begin
        status     = sync_in & en & ~mask;
        gt_d       = gt_q;
        gt_d.irq   = |status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gt_q <= '0;
        else        gt_q <= gt_d;
    end

    assign irq_out = gt_q.irq;

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(|sync_in));

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(|(en & ~mask)));
endmodule

// File: rtl/irq_agg_apb.sv
module irq_agg_apb
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int ADDR_W  = 12
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [WORD_W-1:0]  pwdata,
    output logic [WORD_W-1:0]  prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_out
);
    logic [NUM_SRC-1:0] sync_w, en_w, mask_w, status_w;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    irq_agg_sync #(.W(NUM_SRC)) sync_i (
        .clk   (pclk),
        .rst_n (presetn),
        .d     (irq_src),
        .q     (sync_w)
    );

    irq_agg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) regs_i (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .status  (status_w),
        .prdata  (prdata),
        .en_o    (en_w),
        .mask_o  (mask_w)
    );

    irq_agg_gate #(.NUM_SRC(NUM_SRC)) gate_i (
        .clk     (pclk),
        .rst_n   (presetn),
        .sync_in (sync_w),
        .en      (en_w),
        .mask    (mask_w),
        .status  (status_w),
        .irq_out (irq_out)
    );

    // R6
    lat_chk: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(irq_out) |-> ($past(irq_src, 3) != '0));
endmodule

// File: tb/irq_agg_apb_tb_top.sv
`timescale 1ns/1ps
module irq_agg_apb_tb_top;
    localparam int NUM_SRC = 40;
    localparam int ADDR_W  = 12;
    localparam logic [63:0] IMPL = (NUM_SRC == 64) ? '1 : ((64'h1 << NUM_SRC) - 64'h1);

    logic               pclk = 1'b0;
    logic               presetn = 1'b0;
    logic               psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0]  paddr = '0;
    logic [31:0]        pwdata = '0;
    logic [31:0]        prdata;
    logic               pready, pslverr;
    logic [NUM_SRC-1:0] irq_src = '0;
    logic               irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [63:0] en_m, mk_m, src_m;

    always #10 pclk = ~pclk;

    irq_agg_apb #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) dut_i (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_src(irq_src), .irq_out(irq_out)
    );

    always @(posedge pclk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_cmp = n_cmp + 1;
        if (got !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic apb_wr(input int addr, input logic [31:0] data);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
        paddr = ADDR_W'(addr); pwdata = data;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input int addr, output logic [31:0] data);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = ADDR_W'(addr);
        @(negedge pclk);
        penable = 1'b1;
        #1;
        data = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [63:0] exp_status(input logic [63:0] s, input logic [63:0] e,
                                               input logic [63:0] m);
        return s & e & ~m & IMPL;
    endfunction

    task automatic set_src(input logic [63:0] v);
        @(negedge pclk);
        irq_src = v[NUM_SRC-1:0];
        src_m   = v & IMPL;
    endtask

    task automatic settle();
        for (int k = 0; k < 4; k++) @(negedge pclk);
    endtask

    task automatic check_status(input string req);
        logic [31:0] lo, hi;
        logic [63:0] e;
        e = exp_status(src_m, en_m, mk_m);
        apb_rd('h30, lo);
        apb_rd('h34, hi);
        check(req, {hi, lo}, e);
        check(req, {63'd0, irq_out}, {63'd0, |e});
    endtask

    task automatic wr_en(input logic [63:0] v);
        apb_wr('h00, v[31:0]);
        apb_wr('h04, v[63:32]);
        en_m = v & IMPL;
    endtask

    task automatic wr_mk(input logic [63:0] v);
        apb_wr('h08, v[31:0]);
        apb_wr('h0C, v[63:32]);
        mk_m = v & IMPL;
    endtask

    initial begin
        logic [31:0] rd, rd2;
        int          cnt;
        void'($urandom(32'd2024));
        en_m = '0; mk_m = '0; src_m = '0;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;

        // R1 reset state
        check("R1 irq_out", {63'd0, irq_out}, 64'd0);
        apb_rd('h00, rd); check("R1 en lo", {32'd0, rd}, 64'd0);
        apb_rd('h04, rd); check("R1 en hi", {32'd0, rd}, 64'd0);
        apb_rd('h08, rd); check("R1 mask lo", {32'd0, rd}, 64'd0);
        apb_rd('h0C, rd); check("R1 mask hi", {32'd0, rd}, 64'd0);
        apb_rd('h30, rd); check("R1 status lo", {32'd0, rd}, 64'd0);
        apb_rd('h34, rd); check("R1 status hi", {32'd0, rd}, 64'd0);
        // R8 handshake signals
        check("R8 pready/pslverr", {62'd0, pready, pslverr}, 64'd2);

        // R2 discovery by writing all ones
        wr_en('1);
        apb_rd('h00, rd);  check("R2 en lo ones", {32'd0, rd}, {32'd0, IMPL[31:0]});
        apb_rd('h04, rd2); check("R2 en hi ones", {32'd0, rd2}, {32'd0, IMPL[63:32]});
        cnt = 0;
        for (int b = 0; b < 32; b++) if (rd2[b]) cnt = 32 + b + 1;
        if (cnt == 0) for (int b = 0; b < 32; b++) if (rd[b]) cnt = b + 1;
        check("R2 source count", 64'(cnt), 64'(NUM_SRC));

        // R3 mask readback
        wr_mk('1);
        apb_rd('h08, rd); check("R3 mask lo", {32'd0, rd}, {32'd0, IMPL[31:0]});
        apb_rd('h0C, rd); check("R3 mask hi", {32'd0, rd}, {32'd0, IMPL[63:32]});

        // R4 mask suppresses everything
        set_src('1); settle();
        check_status("R4 all masked");
        wr_mk('0); settle();
        check_status("R4 unmasked");

        // R5 status writes ignored, level held
        apb_wr('h30, 32'h0); apb_wr('h34, 32'h0);
        check_status("R5 status write ignored");
        repeat (20) @(negedge pclk);
        check_status("R5 level held");
        set_src('0); settle();
        check_status("R5 level dropped");

        // R8 unmapped offsets
        apb_rd('h10, rd); check("R8 unmapped 0x10", {32'd0, rd}, 64'd0);
        apb_rd('h38, rd); check("R8 unmapped 0x38", {32'd0, rd}, 64'd0);
        apb_wr('h10, 32'h0); apb_wr('h2C, 32'h0);
        apb_rd('h00, rd); check("R8 unmapped write", {32'd0, rd}, {32'd0, en_m[31:0]});

        // R6 latency of irq_out: rises on third edge after the input changes
        @(negedge pclk);
        irq_src = '0; irq_src[3] = 1'b1; src_m = 64'h8;
        @(negedge pclk); check("R6 after 1 edge", {63'd0, irq_out}, 64'd0);
        @(negedge pclk); check("R6 after 2 edges", {63'd0, irq_out}, 64'd0);
        @(negedge pclk); check("R6 after 3 edges", {63'd0, irq_out}, 64'd1);
        // R6 status read two edges after the input
        @(negedge pclk);
        irq_src = '0; irq_src[5] = 1'b1; src_m = 64'h20;
        apb_rd('h30, rd); check("R6 status after 2 edges", {32'd0, rd}, 64'h20);
        set_src('0); settle();

        // R2 word boundary: source 32 is high bit 0
        wr_en(64'h1_0000_0000);
        set_src(64'h1_8000_0000); settle();
        check_status("R2 boundary source 32");
        apb_rd('h34, rd); check("R2 high bit 0", {32'd0, rd}, 64'd1);

        // R7 random patterns
        for (int it = 0; it < 40; it++) begin
            wr_en({$urandom(), $urandom()});
            wr_mk({$urandom(), $urandom()} & {$urandom(), $urandom()});
            set_src({$urandom(), $urandom()});
            settle();
            check_status("R7 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule